// File: doc/BRIEF.md
# Vectored Interrupt Controller with Bus Acknowledge

This block collects eight interrupt source lines, gates each with a bit of a software-written enable mask, and pulls an active-low interrupt request line whenever any enabled source is true. The request is held as a pull-enable so the line can be wired-OR with other devices: the block only ever pulls it low or lets it go.

A processor reaches the block through a small asynchronous-style register port: an active-low select, a read/write strobe, a 4-bit address and an 8-bit data path. The block answers every access with an active-low transfer acknowledge. On an interrupt acknowledge cycle it returns a programmable 8-bit vector with that same acknowledge, but only while a request is pending. If no request is pending it stays silent, so another device or a bus timeout can answer. All tri-state outputs are shown as a value plus an output enable. The bus here is a plain strobe-and-acknowledge handshake rather than a valid/ready stream: the acknowledge is the only back-pressure, and the processor holds select until it sees it.

Top module: `vec_irq_ctrl`

## Requirements
- R1: `irq_pull` is 1 exactly one clock after a cycle in which `src & mask` is nonzero, and 0 one clock after a cycle in which it is zero; the block never drives the line high.
- R2: The enable mask sits at address 1, can be written and read back, and bit i enables source i.
- R3: Address 0 reads the live source lines as status; writes to address 0 change nothing.
- R4: After reset, the mask reads 0x00, the vector reads 0x0F, `irq_pull` is 0 and no bus output is enabled.
- R5: When `iack_n` is low and a request is pending, the vector register (address 2, writable) is driven on `rdata` with `rdata_oe` one clock later, together with `dtack_n` low and `dtack_oe` high.
- R6: When `iack_n` is low and no request is pending at the first clock of the cycle, neither the data bus nor the acknowledge is enabled for the whole cycle.
- R7: An access with `cs_n` low is acknowledged one clock after select is first seen. A read (`rw`=1) drives the addressed value with the acknowledge; a write (`rw`=0) updates the register once and drives no data.
- R8: With `cs_n` and `iack_n` both high, `rdata_oe` and `dtack_oe` are 0, so both outputs are released in the same cycle the select goes away.
- R9: Addresses other than 0, 1 and 2 read as 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low register select |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data or vector |
| rdata_oe | output | 1 | Data bus output enable |
| iack_n | input | 1 | Active-low interrupt acknowledge |
| dtack_n | output | 1 | Active-low transfer acknowledge value |
| dtack_oe | output | 1 | Transfer acknowledge output enable |
| src | input | 8 | Interrupt source conditions, active high |
| irq_pull | output | 1 | 1 = pull the open-drain request line low |

## Verification
The request path is tried with source patterns that are fully masked, with a single enabled source at the lowest and at the highest bit, and with a cleared mask over active sources. These cases separate a correct bitwise AND from an inverted mask or an OR that covers only part of the vector. Acknowledge cycles are run both with and without a pending request, so that a block which always answers can be told apart from one that answers only when it should. Reads and writes to status, mask, vector and an unused address show whether the address decode and write protection are correct.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VIC_DW = 8;
  localparam int VIC_AW = 4;
  localparam logic [VIC_AW-1:0] ADDR_STATUS = 4'd0;
  localparam logic [VIC_AW-1:0] ADDR_MASK   = 4'd1;
  localparam logic [VIC_AW-1:0] ADDR_VECTOR = 4'd2;
  typedef enum logic [1:0] {CYC_IDLE, CYC_ACKED, CYC_SILENT} cyc_state_e;
endpackage

// File: rtl/vic_regs.sv
module vic_regs #(
  parameter int NSRC = 8,
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [DW-1:0] VEC_RESET = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] src,
  output logic [NSRC-1:0] mask,
  output logic [DW-1:0]   vector,
  output logic [DW-1:0]   rd_val
);
  import vic_pkg::*;
  localparam int PADW = (DW > NSRC) ? DW - NSRC : 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask   <= '0;
      vector <= VEC_RESET;
    end else if (wr_en) begin
      if (addr == ADDR_MASK)   mask   <= wdata[NSRC-1:0];
      if (addr == ADDR_VECTOR) vector <= wdata;
    end
  end

  logic [DW-1:0] src_w, mask_w;
  generate
    if (DW > NSRC) begin : g_pad
      assign src_w  = {{PADW{1'b0}}, src};
      assign mask_w = {{PADW{1'b0}}, mask};
    end else begin : g_nopad
      assign src_w  = src[DW-1:0];
      assign mask_w = mask[DW-1:0];
    end
  endgenerate

  always_comb begin
    case (addr)
      ADDR_STATUS: rd_val = src_w;
      ADDR_MASK:   rd_val = mask_w;
      ADDR_VECTOR: rd_val = vector;
      default:     rd_val = '0;
    endcase
  end
endmodule

// File: rtl/vic_req.sv
module vic_req #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] mask,
  output logic            pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= |(src & mask);
  end
endmodule

// File: rtl/vic_bus.sv
module vic_bus #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rw,
  input  logic          iack_n,
  input  logic          pending,
  input  logic [DW-1:0] vector,
  input  logic [DW-1:0] rd_val,
  output logic          wr_en,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          dtack_n,
  output logic          dtack_oe
);
  import vic_pkg::*;
  cyc_state_e state;
  logic       drive_q;
  logic       active;

  assign active = !cs_n || !iack_n;
  // a register access is taken only on the first clock of a select cycle
  assign wr_en  = (state == CYC_IDLE) && iack_n && !cs_n && !rw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= CYC_IDLE;
      drive_q <= 1'b0;
      rdata   <= '0;
    end else if (!active) begin
      state   <= CYC_IDLE;
      drive_q <= 1'b0;
    end else if (state == CYC_IDLE) begin
      if (!iack_n) begin
        if (pending) begin
          state   <= CYC_ACKED;
          drive_q <= 1'b1;
          rdata   <= vector;
        end else begin
          state   <= CYC_SILENT;
        end
      end else begin
        state   <= CYC_ACKED;
        drive_q <= rw;
        if (rw) rdata <= rd_val;
      end
    end
  end

  assign dtack_oe = (state == CYC_ACKED) && active;
  assign dtack_n  = !dtack_oe;
  assign rdata_oe = drive_q && active;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC = 8,
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [DW-1:0] VEC_RESET = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            rw,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            rdata_oe,
  input  logic            iack_n,
  output logic            dtack_n,
  output logic            dtack_oe,
  input  logic [NSRC-1:0] src,
  output logic            irq_pull
);
  logic [NSRC-1:0] mask;
  logic [DW-1:0]   vector, rd_val;
  logic            wr_en, pending;

  vic_regs #(.NSRC(NSRC), .DW(DW), .AW(AW), .VEC_RESET(VEC_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .src(src), .mask(mask), .vector(vector), .rd_val(rd_val)
  );

  vic_req #(.NSRC(NSRC)) u_req (
    .clk(clk), .rst_n(rst_n), .src(src), .mask(mask), .pending(pending)
  );

  vic_bus #(.DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .iack_n(iack_n),
    .pending(pending), .vector(vector), .rd_val(rd_val), .wr_en(wr_en),
    .rdata(rdata), .rdata_oe(rdata_oe), .dtack_n(dtack_n), .dtack_oe(dtack_oe)
  );

  assign irq_pull = pending;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            rw,
  input logic            iack_n,
  input logic            rdata_oe,
  input logic            dtack_oe,
  input logic            dtack_n,
  input logic [NSRC-1:0] src,
  input logic            irq_pull
);
  AST_REQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull) |-> $past(src) != '0); // R1
  AST_NO_SOURCE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |=> !irq_pull); // R1
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && iack_n) |-> (!rdata_oe && !dtack_oe)); // R8
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && iack_n && !rw && $stable(rw) && $stable(cs_n) && $stable(iack_n)) |-> !rdata_oe); // R7
  AST_IACK_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dtack_oe) && !iack_n && $stable(iack_n)) |-> $past(irq_pull)); // R6
  AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    dtack_oe |-> !dtack_n); // R5
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .iack_n(iack_n),
  .rdata_oe(rdata_oe), .dtack_oe(dtack_oe), .dtack_n(dtack_n),
  .src(src), .irq_pull(irq_pull)
);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rw = 1'b1, iack_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, src = '0;
  logic [7:0] rdata;
  logic       rdata_oe, dtack_n, dtack_oe, irq_pull;

  int checks = 0, errors = 0;
  bit done = 0;

  bit         q_rd[$];
  logic [7:0] q_val[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  vec_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .iack_n(iack_n),
    .dtack_n(dtack_n), .dtack_oe(dtack_oe), .src(src), .irq_pull(irq_pull)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per new acknowledge
  bit prev_ack = 0;
  always @(negedge clk) begin
    bit ack_now;
    ack_now = dtack_oe && !dtack_n;
    if (ack_now && !prev_ack) begin
      if (q_rd.size() == 0) begin
        chk(0, "R6 unexpected acknowledge", 1, 0);
      end else begin
        bit rd_e; logic [7:0] v_e; string t_e;
        rd_e = q_rd.pop_front(); v_e = q_val.pop_front(); t_e = q_tag.pop_front();
        chk(rdata_oe == rd_e, {t_e, " data enable"}, int'(rdata_oe), int'(rd_e));
        if (rd_e) chk(rdata == v_e, {t_e, " data"}, int'(rdata), int'(v_e));
      end
    end
    prev_ack = ack_now;
  end

  task automatic bus_cycle(input bit rd, input logic [3:0] a, input logic [7:0] wd,
                           input logic [7:0] exp_v, input string tag);
    @(negedge clk);
    cs_n = 1'b0; rw = rd; addr = a; wdata = wd;
    q_rd.push_back(rd); q_val.push_back(exp_v); q_tag.push_back(tag);
    @(negedge clk);
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b1;
    #1;
    chk(!dtack_oe && !rdata_oe, "R8 release on deselect", int'({dtack_oe, rdata_oe}), 0);
  endtask

  task automatic iack_cycle(input bit expect_ans, input logic [7:0] exp_v);
    @(negedge clk);
    iack_n = 1'b0;
    if (expect_ans) begin
      q_rd.push_back(1'b1); q_val.push_back(exp_v); q_tag.push_back("R5 vector");
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!expect_ans)
        chk(!dtack_oe && !rdata_oe, "R6 silent acknowledge", int'({dtack_oe, rdata_oe}), 0);
    end
    iack_n = 1'b1;
    #1;
    chk(!dtack_oe && !rdata_oe, "R8 release on iack end", int'({dtack_oe, rdata_oe}), 0);
  endtask

  task automatic set_src(input logic [7:0] s, input bit exp_irq, input string tag);
    @(negedge clk);
    src = s;
    @(negedge clk);
    chk(irq_pull == exp_irq, tag, int'(irq_pull), int'(exp_irq));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!irq_pull && !dtack_oe && !rdata_oe, "R4 reset outputs",
        int'({irq_pull, dtack_oe, rdata_oe}), 0);
    bus_cycle(1, 4'd2, 8'h00, 8'h0F, "R4 vector reset");
    bus_cycle(1, 4'd1, 8'h00, 8'h00, "R4 mask reset");
    bus_cycle(0, 4'd1, 8'hA5, 8'h00, "R7 write mask");
    bus_cycle(1, 4'd1, 8'h00, 8'hA5, "R2 mask readback");
    set_src(8'h5A, 1'b0, "R1 fully masked sources");
    bus_cycle(1, 4'd0, 8'h00, 8'h5A, "R3 status live");
    bus_cycle(0, 4'd0, 8'hFF, 8'h00, "R3 status write");
    bus_cycle(1, 4'd0, 8'h00, 8'h5A, "R3 status unchanged");
    iack_cycle(1'b0, 8'h00);
    set_src(8'h01, 1'b1, "R1 lowest source");
    bus_cycle(0, 4'd2, 8'h42, 8'h00, "R7 write vector");
    iack_cycle(1'b1, 8'h42);
    set_src(8'h80, 1'b1, "R1 highest source");
    set_src(8'h00, 1'b0, "R1 no source");
    bus_cycle(0, 4'd5, 8'h3C, 8'h00, "R9 unused write");
    bus_cycle(1, 4'd5, 8'h00, 8'h00, "R9 unused read");
    bus_cycle(1, 4'd1, 8'h00, 8'hA5, "R9 mask kept");
    bus_cycle(1, 4'd2, 8'h00, 8'h42, "R9 vector kept");
    @(negedge clk); src = 8'hFF;
    bus_cycle(0, 4'd1, 8'h00, 8'h00, "R2 clear mask");
    @(negedge clk);
    chk(!irq_pull, "R1 mask cleared", int'(irq_pull), 0);
    iack_cycle(1'b0, 8'h00);
    repeat (2) @(negedge clk);
    chk(q_rd.size() == 0, "R7 missing acknowledge", q_rd.size(), 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule